// File: doc/BRIEF.md
# Grouped Interrupt Expander

This block gathers a wide set of peripheral interrupt sources and presents them to a CPU as a small number of interrupt lines. The sources are arranged as `NUM_GROUPS` groups of `GROUP_SIZE`. By default that is 12 groups of 8, which gives 96 sources on 12 lines. Each source has a pending flag and an enable bit. A group raises its CPU line when a source in it is both flagged and enabled.

When the CPU acknowledges a line, the block does three things. It picks the winning source in that group. It clears that source's flag. It returns the source's entry from a vector table that software can rewrite. The vector is ready after a fixed fetch latency of `FETCH_LAT` cycles, 8 by default.

A per-group acknowledge bit holds a line quiet after it has fired, until software releases it. When several groups become eligible in the same cycle, the lowest-numbered group goes first. The reset input is asserted asynchronously. Its release is synchronised inside the block, so the block leaves reset two clock edges after `rst_n` rises.

Top module: `grouped_irq_expander`

## Requirements
- R1: After reset `cpu_int_o` and `vec_valid_o` are zero, and every flag, enable bit and acknowledge bit is clear. A source edge with no enable write therefore raises no line.
- R2: A source flag is set on a rising edge of its input, whatever its enable bit holds. An input held high sets its flag once only.
- R3: A group is eligible when it has a flagged and enabled source and its acknowledge bit is clear. An asserted line stays high for exactly one cycle and sets the group's acknowledge bit. The line stays low until `ackclr_i[g]` clears that bit. If the bit is set and cleared in the same cycle, setting wins.
- R4: If several groups are eligible in one cycle, only the lowest-numbered group asserts its line in that cycle.
- R5: An acknowledge (`cpu_ack_i` high) raises `vec_valid_o` for exactly one cycle. That cycle is the `FETCH_LAT`-th, counting the acknowledge cycle as the first. An acknowledge that arrives while a fetch is running is ignored and clears no flag.
- R6: On an accepted acknowledge of group g, the lowest-numbered flagged and enabled source of g is selected, and its flag is cleared. `vec_src_o` returns g*GROUP_SIZE + position, and `vec_o` returns that source's table entry.
- R7: If the acknowledged group has no flagged and enabled source, `vec_o` and `vec_src_o` return zero and no flag changes.
- R8: A cycle with `vt_wr_i` high writes `vt_data_i` into table entry `vt_addr_i`. The vector is captured at the acknowledge edge, so a later write does not change the vector being returned.
- R9: A cycle with `en_wr_i` high writes `en_data_i` (bit b belongs to source position b) into the enable bits of group `en_grp_i`. Other groups keep their enable bits.
- R10: A flagged source whose enable bit is clear raises no line and is not selected. It keeps its flag, and it takes part once it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| src_i | input | NUM_GROUPS*GROUP_SIZE | Peripheral interrupt inputs, source s = group*GROUP_SIZE + position |
| en_wr_i | input | 1 | Enable-write strobe |
| en_grp_i | input | clog2(NUM_GROUPS) | Group whose enable bits are written |
| en_data_i | input | GROUP_SIZE | New enable bits for that group |
| ackclr_i | input | NUM_GROUPS | One bit per group: clears that group's acknowledge bit |
| vt_wr_i | input | 1 | Vector table write strobe |
| vt_addr_i | input | clog2(NUM_GROUPS*GROUP_SIZE) | Table entry to write |
| vt_data_i | input | VEC_W | Vector to store |
| cpu_ack_i | input | 1 | CPU acknowledge of a line |
| cpu_ack_grp_i | input | clog2(NUM_GROUPS) | Group being acknowledged |
| cpu_int_o | output | NUM_GROUPS | CPU interrupt lines, bit g for group g |
| vec_valid_o | output | 1 | Fetched vector is valid this cycle |
| vec_o | output | VEC_W | Fetched vector |
| vec_src_o | output | clog2(NUM_GROUPS*GROUP_SIZE) | Index of the selected source |

## Verification
The bench builds the block with 4 groups of 4 sources, 16-bit vectors and the default 8-cycle fetch latency. With 4-bit groups, every combination of flag pattern and enable pattern can be tried in every group. That covers all 1024 cases of in-group priority, flag clearing and empty-group fetches, and each expected winner and each expected vector is computed in the bench. Four groups also leave room for directed runs of cross-group ordering, ignored repeat acknowledges, held-high inputs and table writes made during a fetch.

// File: rtl/irqx_pkg.sv
package irqx_pkg;
  typedef enum logic {
    FETCH_IDLE = 1'b0,
    FETCH_RUN  = 1'b1
  } fetch_st_e;
endpackage

// File: rtl/irqx_flag_bank.sv
module irqx_flag_bank #(
  parameter int NG = 12,
  parameter int GS = 8,
  localparam int NSRC = NG * GS,
  localparam int GW = (NG > 1) ? $clog2(NG) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            en_wr_i,
  input  logic [GW-1:0]   en_grp_i,
  input  logic [GS-1:0]   en_data_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o,
  output logic [NG-1:0]   grp_pend_o
);
  logic [NSRC-1:0] src_q, flag_q, flag_d, en_q, en_d;

  always_comb begin
    // a fresh edge beats a clear in the same cycle
    flag_d = (flag_q & ~clr_i) | (src_i & ~src_q);
    en_d   = en_q;
    for (int g = 0; g < NG; g++) begin
      if (en_wr_i && (en_grp_i == GW'(g))) en_d[g*GS +: GS] = en_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      src_q  <= src_i;
      flag_q <= flag_d;
      en_q   <= en_d;
    end
  end

  assign pend_o = flag_q & en_q;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    assign grp_pend_o[g] = |pend_o[g*GS +: GS];
  end
endmodule

// File: rtl/irqx_line_arb.sv
module irqx_line_arb #(
  parameter int NG = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NG-1:0] grp_pend_i,
  input  logic [NG-1:0] ackclr_i,
  output logic [NG-1:0] int_o
);
  logic [NG-1:0] ack_q, ack_d, elig;

  always_comb begin
    elig  = grp_pend_i & ~ack_q;
    int_o = elig & (~elig + NG'(1));  // lowest-numbered eligible group
    ack_d = (ack_q & ~ackclr_i) | int_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= '0;
    else        ack_q <= ack_d;
  end
endmodule

// File: rtl/irqx_vec_fetch.sv
module irqx_vec_fetch
  import irqx_pkg::*;
#(
  parameter int NG = 12,
  parameter int GS = 8,
  parameter int VEC_W = 32,
  parameter int FETCH_LAT = 8,
  localparam int NSRC = NG * GS,
  localparam int GW = (NG > 1) ? $clog2(NG) : 1,
  localparam int SW = $clog2(NSRC),
  localparam int CW = $clog2(FETCH_LAT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_ack_i,
  input  logic [GW-1:0]    cpu_ack_grp_i,
  input  logic [NSRC-1:0]  pend_i,
  input  logic             vt_wr_i,
  input  logic [SW-1:0]    vt_addr_i,
  input  logic [VEC_W-1:0] vt_data_i,
  output logic [NSRC-1:0]  clr_o,
  output logic             vec_valid_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [SW-1:0]    vec_src_o
);
  logic [VEC_W-1:0] vt_q [NSRC];
  fetch_st_e        st_q, st_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic [SW-1:0]    idx_q, idx_d, sel;
  logic [GS-1:0]    grp_bits;
  logic             accept, hit;
  int               pos;

  always_ff @(posedge clk) begin
    if (vt_wr_i && (int'(vt_addr_i) < NSRC)) vt_q[vt_addr_i] <= vt_data_i;
  end

  always_comb begin
    grp_bits = '0;
    for (int g = 0; g < NG; g++) begin
      if (cpu_ack_grp_i == GW'(g)) grp_bits = pend_i[g*GS +: GS];
    end
    hit = 1'b0;
    pos = 0;
    for (int b = GS - 1; b >= 0; b--) begin
      if (grp_bits[b]) begin
        hit = 1'b1;
        pos = b;
      end
    end
    sel    = SW'(int'(cpu_ack_grp_i) * GS + pos);
    accept = cpu_ack_i && (st_q == FETCH_IDLE) && (int'(cpu_ack_grp_i) < NG);

    clr_o = '0;
    st_d  = st_q;
    cnt_d = cnt_q;
    vec_d = vec_q;
    idx_d = idx_q;
    if (accept) begin
      if (hit) clr_o[sel] = 1'b1;
      st_d  = FETCH_RUN;
      cnt_d = CW'(FETCH_LAT - 2);
      vec_d = hit ? vt_q[sel] : '0;
      idx_d = hit ? sel : '0;
    end else if (st_q == FETCH_RUN) begin
      if (cnt_q == '0) st_d = FETCH_IDLE;
      else             cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FETCH_IDLE;
      cnt_q <= '0;
      vec_q <= '0;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      vec_q <= vec_d;
      idx_q <= idx_d;
    end
  end

  assign vec_valid_o = (st_q == FETCH_RUN) && (cnt_q == '0);
  assign vec_o       = vec_q;
  assign vec_src_o   = idx_q;
endmodule

// File: rtl/grouped_irq_expander.sv
module grouped_irq_expander #(
  parameter int NUM_GROUPS = 12,
  parameter int GROUP_SIZE = 8,
  parameter int VEC_W = 32,
  parameter int FETCH_LAT = 8,
  localparam int NSRC = NUM_GROUPS * GROUP_SIZE,
  localparam int GW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int SW = $clog2(NSRC)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC-1:0]       src_i,
  input  logic                  en_wr_i,
  input  logic [GW-1:0]         en_grp_i,
  input  logic [GROUP_SIZE-1:0] en_data_i,
  input  logic [NUM_GROUPS-1:0] ackclr_i,
  input  logic                  vt_wr_i,
  input  logic [SW-1:0]         vt_addr_i,
  input  logic [VEC_W-1:0]      vt_data_i,
  input  logic                  cpu_ack_i,
  input  logic [GW-1:0]         cpu_ack_grp_i,
  output logic [NUM_GROUPS-1:0] cpu_int_o,
  output logic                  vec_valid_o,
  output logic [VEC_W-1:0]      vec_o,
  output logic [SW-1:0]         vec_src_o
);
  logic                  rst_meta, rst_sync_n;
  logic [NSRC-1:0]       pend, clr;
  logic [NUM_GROUPS-1:0] grp_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_sync_n, rst_meta} <= 2'b00;
    else        {rst_sync_n, rst_meta} <= {rst_meta, 1'b1};
  end

  irqx_flag_bank #(.NG(NUM_GROUPS), .GS(GROUP_SIZE)) u_flags (
    .clk(clk), .rst_n(rst_sync_n), .src_i(src_i), .en_wr_i(en_wr_i),
    .en_grp_i(en_grp_i), .en_data_i(en_data_i), .clr_i(clr),
    .pend_o(pend), .grp_pend_o(grp_pend)
  );

  irqx_line_arb #(.NG(NUM_GROUPS)) u_arb (
    .clk(clk), .rst_n(rst_sync_n), .grp_pend_i(grp_pend),
    .ackclr_i(ackclr_i), .int_o(cpu_int_o)
  );

  irqx_vec_fetch #(.NG(NUM_GROUPS), .GS(GROUP_SIZE), .VEC_W(VEC_W),
                   .FETCH_LAT(FETCH_LAT)) u_fetch (
    .clk(clk), .rst_n(rst_sync_n), .cpu_ack_i(cpu_ack_i),
    .cpu_ack_grp_i(cpu_ack_grp_i), .pend_i(pend), .vt_wr_i(vt_wr_i),
    .vt_addr_i(vt_addr_i), .vt_data_i(vt_data_i), .clr_o(clr),
    .vec_valid_o(vec_valid_o), .vec_o(vec_o), .vec_src_o(vec_src_o)
  );
endmodule

// File: rtl/irqx_chk.sv
module irqx_chk #(
  parameter int NG = 12,
  parameter int GS = 8,
  parameter int SW = 7,
  parameter int GW = 4,
  parameter int VEC_W = 32,
  parameter int FETCH_LAT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_ack_i,
  input logic [GW-1:0]    cpu_ack_grp_i,
  input logic [NG-1:0]    cpu_int_o,
  input logic             vec_valid_o,
  input logic [VEC_W-1:0] vec_o,
  input logic [SW-1:0]    vec_src_o
);
  localparam int KW = $clog2(FETCH_LAT) + 1;
  logic [KW-1:0] age_q;
  logic [GW-1:0] grp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
      grp_q <= '0;
    end else if (age_q == '0) begin
      if (cpu_ack_i && (int'(cpu_ack_grp_i) < NG)) begin
        age_q <= KW'(1);
        grp_q <= cpu_ack_grp_i;
      end
    end else if (age_q == KW'(FETCH_LAT - 1)) begin
      age_q <= '0;
    end else begin
      age_q <= age_q + KW'(1);
    end
  end

  // R4
  line_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cpu_int_o));

  // R3
  line_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_int_o != '0) |=> ((cpu_int_o & $past(cpu_int_o)) == '0));

  // R5
  fetch_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o == (age_q == KW'(FETCH_LAT - 1)));

  // R5
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |=> !vec_valid_o);

  // R6
  src_in_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> ((int'(vec_src_o) / GS == int'(grp_q)) ||
                     (vec_src_o == '0 && vec_o == '0)));
endmodule

bind grouped_irq_expander irqx_chk #(
  .NG(NUM_GROUPS), .GS(GROUP_SIZE), .SW(SW), .GW(GW),
  .VEC_W(VEC_W), .FETCH_LAT(FETCH_LAT)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .cpu_ack_i(cpu_ack_i),
  .cpu_ack_grp_i(cpu_ack_grp_i), .cpu_int_o(cpu_int_o),
  .vec_valid_o(vec_valid_o), .vec_o(vec_o), .vec_src_o(vec_src_o)
);

// File: tb/grouped_irq_expander_bench.sv
module grouped_irq_expander_bench;
  localparam int NG = 4, GS = 4, VW = 16, LAT = 8;
  localparam int NS = NG * GS, GW = 2, SW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic en_wr = 1'b0, vt_wr = 1'b0, ack = 1'b0;
  logic [GW-1:0] en_grp = '0, ack_grp = '0;
  logic [GS-1:0] en_data = '0;
  logic [NG-1:0] ackclr = '0, cpu_int;
  logic [SW-1:0] vt_addr = '0, vsrc;
  logic [VW-1:0] vt_data = '0, vec;
  logic vvalid;
  int n_cmp = 0, n_bad = 0;

  always #4 clk = ~clk;

  grouped_irq_expander #(.NUM_GROUPS(NG), .GROUP_SIZE(GS), .VEC_W(VW),
                         .FETCH_LAT(LAT)) u_grouped_irq_expander (
    .clk(clk), .rst_n(rst_n), .src_i(src), .en_wr_i(en_wr),
    .en_grp_i(en_grp), .en_data_i(en_data), .ackclr_i(ackclr),
    .vt_wr_i(vt_wr), .vt_addr_i(vt_addr), .vt_data_i(vt_data),
    .cpu_ack_i(ack), .cpu_ack_grp_i(ack_grp), .cpu_int_o(cpu_int),
    .vec_valid_o(vvalid), .vec_o(vec), .vec_src_o(vsrc)
  );

  function automatic logic [VW-1:0] vexp(input int i);
    return VW'(16'hA5C3 ^ (i * 16'h00F1));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; src = '0; en_wr = 0; vt_wr = 0; ack = 0; ackclr = '0;
    step(); step();
    rst_n = 1'b1;
    step(); step(); step();
  endtask

  task automatic write_en(input int g, input logic [GS-1:0] d);
    en_wr = 1'b1; en_grp = GW'(g); en_data = d;
    step();
    en_wr = 1'b0;
  endtask

  // acknowledge group g; check valid timing over n cycles and the vector
  task automatic fetch(input int g, input int n, input int exp_src,
                       input logic [VW-1:0] exp_vec, input int reack_at);
    ack = 1'b1; ack_grp = GW'(g);
    for (int k = 1; k <= n; k++) begin
      step();
      chk("R5 valid timing", 32'(vvalid), 32'(k == LAT - 1));
      if (k == LAT - 1) begin
        chk("R6 vec_src_o", 32'(vsrc), 32'(exp_src));
        chk("R6 vec_o", 32'(vec), 32'(exp_vec));
      end
      ack = (k == reack_at);
    end
    ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state, enables clear so a source edge raises no line
    chk("R1 int after reset", 32'(cpu_int), 0);
    chk("R1 valid after reset", 32'(vvalid), 0);
    src[0] = 1'b1; step(); src = '0;
    chk("R1 no line with reset enables", 32'(cpu_int), 0);

    for (int i = 0; i < NS; i++) begin
      vt_wr = 1'b1; vt_addr = SW'(i); vt_data = vexp(i);
      step();
    end
    vt_wr = 1'b0;

    // R4: simultaneous groups, lowest first
    do_reset();
    for (int g = 0; g < NG; g++) write_en(g, '1);
    src[4] = 1'b1; src[12] = 1'b1; step(); src = '0;
    chk("R4 group 1 first", 32'(cpu_int), 32'b0010);
    step();
    chk("R4 group 3 next", 32'(cpu_int), 32'b1000);
    step();
    chk("R3 lines quiet", 32'(cpu_int), 0);

    // R2: enable does not gate capture
    do_reset();
    src[5] = 1'b1; step(); src = '0; step();
    chk("R10 disabled flag raises no line", 32'(cpu_int), 0);
    write_en(1, 4'b0010);
    chk("R2 captured while disabled", 32'(cpu_int), 32'b0010);

    // R2: level held high sets flag once
    do_reset();
    write_en(0, '1);
    src[0] = 1'b1; step();
    chk("R2 edge sets flag", 32'(cpu_int), 1);
    fetch(0, LAT, 0, vexp(0), 0);
    ackclr[0] = 1'b1; step(); ackclr = '0;
    chk("R2 held level no re-flag", 32'(cpu_int), 0);
    src[0] = 1'b0; step(); src[0] = 1'b1; step(); src = '0;
    chk("R2 new edge re-flags", 32'(cpu_int), 1);

    // R5: acknowledge during a running fetch is ignored
    do_reset();
    write_en(0, '1);
    src[1:0] = 2'b11; step(); src = '0; step();
    fetch(0, LAT + 6, 0, vexp(0), 3);
    ackclr[0] = 1'b1; step(); ackclr = '0;
    chk("R5 ignored ack left flag", 32'(cpu_int), 1);

    // R6 R7 R9 R10 R3: sweep of flag and enable patterns in every group
    for (int g = 0; g < NG; g++) begin
      for (int f = 0; f < 16; f++) begin
        for (int e = 0; e < 16; e++) begin
          int w, rem;
          w = -1;
          for (int b = GS - 1; b >= 0; b--) if (((f & e) >> b) & 1) w = b;
          do_reset();
          write_en(g, GS'(e));
          src[g*GS +: GS] = GS'(f); step(); src = '0;
          chk("R3 R9 line raised", 32'(cpu_int), (f & e) != 0 ? (1 << g) : 0);
          step();
          chk("R3 one-cycle line", 32'(cpu_int), 0);
          if (w >= 0) fetch(g, LAT, g * GS + w, vexp(g * GS + w), 0);
          else        fetch(g, LAT, 0, '0, 0);   // R7
          rem = (w >= 0) ? (f & ~(1 << w)) : f;
          ackclr[g] = 1'b1; en_wr = 1'b1; en_grp = GW'(g); en_data = '1;
          step();
          ackclr = '0; en_wr = 1'b0;
          chk("R6 R7 R10 remaining flags", 32'(cpu_int), rem != 0 ? (1 << g) : 0);
        end
      end
    end

    // R8: table write after acknowledge does not change returned vector
    do_reset();
    write_en(0, '1);
    src[2] = 1'b1; step(); src = '0;
    ack = 1'b1; ack_grp = '0;
    for (int k = 1; k <= LAT; k++) begin
      step();
      ack = 1'b0;
      vt_wr = (k == 2); vt_addr = SW'(2); vt_data = 16'hBEEF;
      if (k == LAT - 1) chk("R8 vector captured at ack", 32'(vec), 32'(vexp(2)));
    end
    vt_wr = 1'b0;
    ackclr = '1; src[3] = 1'b1; step(); ackclr = '0; src = '0;
    fetch(0, LAT, 3, vexp(3), 0);
    src[2] = 1'b1; step(); src = '0;
    fetch(0, LAT, 2, 16'hBEEF, 0);   // R8 new entry used

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule